// File: doc/BRIEF.md
# Warp Barrier Synchroniser

This unit holds warps at named rendezvous points until a group of them has gathered. A warp that reaches a barrier raises a one-cycle arrival strobe. The strobe carries the warp's index, a barrier identifier, the number of distinct warps that must gather at that identifier, and the warp's current active-thread count. The unit keeps the warp parked, with its stall line high, until enough distinct warps have arrived at the same identifier. It then lets every member go in the same cycle and hands back each member's saved thread count.

A small table of barrier entries, one member bit-vector per entry, lets several identifiers be open at once. An entry is claimed on the first arrival at a new identifier and is freed when its group is released, so the entry can be used again. The warp whose arrival completes a group never stalls. An arrival that would need a new entry while every entry is busy is rejected, and a one-cycle error pulse reports the rejection. The warp scheduler uses the stall and resume lines to park and restart warps, and uses the restored counts to reload each warp's active-thread count.

Top module: `warp_barrier_unit`

## Requirements
- R1: After reset no warp is stalled, no resume pulse or error pulse is raised, and every barrier entry is free.
- R2: An arrival that does not complete its group causes the arriving warp's stall bit to be set at the next clock edge. The warp's arriving thread count is saved and shows on its slice of `warp_threads`, where warp w uses bits [w*THR_W +: THR_W].
- R3: When an arrival brings the number of distinct members of an identifier to at least the expected count carried by that arrival, every member is released at the next edge. Each member's stall bit clears, its resume bit pulses, and its saved count shows on `warp_threads`.
- R4: The warp whose arrival completes a group never raises its stall bit. It gets a resume pulse in the release cycle, and its arriving thread count is restored.
- R5: A repeated arrival by a warp that is already a member of the same identifier does not raise the member count. It changes no stall or resume output.
- R6: Groups at different identifiers are tracked independently at the same time. Releasing one group leaves the members of the others stalled.
- R7: An arrival at an identifier that has no entry, made while all NUM_SLOTS entries are in use and needing more than one warp, pulses `arrive_error` for one cycle. The arrival is otherwise ignored: the warp is not stalled.
- R8: A released entry becomes free and can be claimed by a later arrival at a new identifier.
- R9: An arrival with an expected count of 0 or 1 completes at once and claims no entry. This works even when the table is full, and it raises no error.
- R10: A resume bit is high for exactly one cycle for each release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arrive_valid | input | 1 | One-cycle arrival strobe |
| arrive_warp | input | $clog2(NUM_WARPS) | Index of the arriving warp |
| arrive_id | input | ID_W | Barrier identifier |
| arrive_need | input | $clog2(NUM_WARPS+1) | Number of distinct warps expected at this identifier |
| arrive_threads | input | THR_W | Active-thread count of the arriving warp |
| warp_stall | output | NUM_WARPS | Per-warp parked flag |
| warp_resume | output | NUM_WARPS | Per-warp one-cycle release pulse |
| warp_threads | output | NUM_WARPS*THR_W | Per-warp saved thread count |
| arrive_error | output | 1 | One-cycle pulse for an arrival rejected because the table is full |

## Verification
The assertions assume that a warp whose stall bit is high does not arrive again, except as a repeat at the identifier it already waits on. They also assume that all arrivals at one identifier carry the same expected count. The directed tests keep to both rules: parked warps are only brought back as deliberate repeats, and each group uses one expected count throughout. Within those rules the tests cover the edge cases: a full table, repeat arrivals, one-warp groups while the table is full, and reuse of a freed entry.

// File: rtl/barrier_pkg.sv
// Shared types for the warp barrier unit.
// Assumes nothing beyond IEEE 1800-2017 packages.
package barrier_pkg;

    // Classification of one arrival strobe.
    typedef enum logic [2:0] {
        ARR_IDLE   = 3'd0,  // no strobe
        ARR_JOIN   = 3'd1,  // warp parks at an existing or new entry
        ARR_DONE   = 3'd2,  // arrival completes its group
        ARR_DUP    = 3'd3,  // warp already a member: ignored
        ARR_REJECT = 3'd4   // no entry free: ignored with error
    } arr_kind_e;

endpackage

// File: rtl/barrier_lookup.sv
// Combinational search of the barrier entry table.
// Finds the entry holding the arriving identifier and the lowest free entry.
// Also reports the member count of the matching entry and whether the
// arriving warp is already one of its members.
// Assumes valid entries hold distinct identifiers.
module barrier_lookup #(
    parameter int NUM_WARPS = 8,
    parameter int NUM_SLOTS = 4,
    parameter int ID_W      = 4,
    parameter int SLOT_W    = 2,
    parameter int CNT_W     = 4,
    parameter int WARP_W    = 3
) (
    input  logic [NUM_SLOTS-1:0]                slot_vld,
    input  logic [NUM_SLOTS-1:0][ID_W-1:0]      slot_id,
    input  logic [NUM_SLOTS-1:0][NUM_WARPS-1:0] slot_mem,
    input  logic [ID_W-1:0]                     req_id,
    input  logic [WARP_W-1:0]                   req_warp,
    output logic [NUM_SLOTS-1:0]                hit_vec,
    output logic                                hit,
    output logic [SLOT_W-1:0]                   hit_idx,
    output logic                                free_any,
    output logic [SLOT_W-1:0]                   free_idx,
    output logic [CNT_W-1:0]                    hit_cnt,
    output logic                                hit_member
);

    // Identifier match per entry.
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            hit_vec[s] = slot_vld[s] && (slot_id[s] == req_id);
        end
    end

    // Encode the match and pick the lowest free entry.
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (hit_vec[s]) begin
                hit     = 1'b1;
                hit_idx = SLOT_W'(s);
            end
            if (!slot_vld[s]) begin
                free_any = 1'b1;
                free_idx = SLOT_W'(s);
            end
        end
    end

    // Member count and membership of the matching entry.
    always_comb begin
        hit_cnt    = '0;
        hit_member = 1'b0;
        if (hit) begin
            hit_cnt    = CNT_W'($countones(slot_mem[hit_idx]));
            hit_member = slot_mem[hit_idx][req_warp];
        end
    end

endmodule

// File: rtl/barrier_warp_state.sv
// Per-warp park state: stall flag, saved thread count and resume pulse.
// Assumes park and release never hit the same warp in the same cycle.
module barrier_warp_state #(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             park_i,
    input  logic             release_i,
    input  logic             load_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             stall_o,
    output logic             resume_o,
    output logic [THR_W-1:0] saved_o
);

    // Stall flag: set on park, cleared on release.
    always_ff @(posedge clk) begin
        if (!rst_n)         stall_o <= 1'b0;
        else if (park_i)    stall_o <= 1'b1;
        else if (release_i) stall_o <= 1'b0;
    end

    // One-cycle resume pulse on release.
    always_ff @(posedge clk) begin
        if (!rst_n) resume_o <= 1'b0;
        else        resume_o <= release_i;
    end

    // Capture the warp's thread count on an accepted arrival.
    always_ff @(posedge clk) begin
        if (!rst_n)      saved_o <= '0;
        else if (load_i) saved_o <= thr_i;
    end

    // R3: a stall only ends through a release.
    assert_stall_ends_by_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_o) |-> resume_o);

    // R3: a resumed warp is not stalled.
    assert_resume_not_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> !stall_o);

    // R2: the saved count is held while parked.
    assert_saved_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && $past(stall_o)) |-> $stable(saved_o));

    // R10: resume lasts one cycle unless a new release follows.
    assert_resume_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_o && !release_i) |=> !resume_o);

endmodule

// File: rtl/warp_barrier_unit.sv
// Warp barrier unit: parks arriving warps per barrier identifier and
// releases a group once its distinct member count reaches the expected count.
// Assumes at most one arrival per cycle, that a stalled warp only re-arrives
// at its own identifier, and that arrivals at one identifier share a count.
module warp_barrier_unit
    import barrier_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int NUM_SLOTS = 4,
    parameter int ID_W      = 4,
    parameter int THR_W     = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           arrive_valid,
    input  logic [$clog2(NUM_WARPS)-1:0]   arrive_warp,
    input  logic [ID_W-1:0]                arrive_id,
    input  logic [$clog2(NUM_WARPS+1)-1:0] arrive_need,
    input  logic [THR_W-1:0]               arrive_threads,
    output logic [NUM_WARPS-1:0]           warp_stall,
    output logic [NUM_WARPS-1:0]           warp_resume,
    output logic [NUM_WARPS*THR_W-1:0]     warp_threads,
    output logic                           arrive_error
);

    localparam int WARP_W = $clog2(NUM_WARPS);
    localparam int CNT_W  = $clog2(NUM_WARPS + 1);
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic [NUM_SLOTS-1:0]                slot_vld;
    logic [NUM_SLOTS-1:0][ID_W-1:0]      slot_id;
    logic [NUM_SLOTS-1:0][NUM_WARPS-1:0] slot_mem;

    logic [NUM_SLOTS-1:0] hit_vec;
    logic                 hit, free_any, hit_member;
    logic [SLOT_W-1:0]    hit_idx, free_idx;
    logic [CNT_W-1:0]     hit_cnt;

    arr_kind_e            kind;
    logic [CNT_W:0]       total;
    logic [NUM_WARPS-1:0] arr_oh, park_mask, rel_mask, load_mask;

    barrier_lookup #(
        .NUM_WARPS(NUM_WARPS), .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W),
        .SLOT_W(SLOT_W), .CNT_W(CNT_W), .WARP_W(WARP_W)
    ) u_lookup (
        .slot_vld(slot_vld), .slot_id(slot_id), .slot_mem(slot_mem),
        .req_id(arrive_id), .req_warp(arrive_warp),
        .hit_vec(hit_vec), .hit(hit), .hit_idx(hit_idx),
        .free_any(free_any), .free_idx(free_idx),
        .hit_cnt(hit_cnt), .hit_member(hit_member)
    );

    // Classify the arrival and form the per-warp park, release and load masks.
    always_comb begin
        arr_oh = '0;
        if (arrive_valid) arr_oh[arrive_warp] = 1'b1;
        total = {1'b0, hit_cnt} + 1'b1;
        if (!arrive_valid)                      kind = ARR_IDLE;
        else if (hit && hit_member)             kind = ARR_DUP;
        else if (total >= {1'b0, arrive_need})  kind = ARR_DONE;
        else if (hit || free_any)               kind = ARR_JOIN;
        else                                    kind = ARR_REJECT;
        park_mask = (kind == ARR_JOIN) ? arr_oh : '0;
        load_mask = (kind == ARR_JOIN || kind == ARR_DONE) ? arr_oh : '0;
        rel_mask  = '0;
        if (kind == ARR_DONE) rel_mask = arr_oh | (hit ? slot_mem[hit_idx] : '0);
    end

    // Entry table: claim, extend and free entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld <= '0;
            slot_id  <= '0;
            slot_mem <= '0;
        end else if (kind == ARR_DONE && hit) begin
            slot_vld[hit_idx] <= 1'b0;
            slot_mem[hit_idx] <= '0;
        end else if (kind == ARR_JOIN && hit) begin
            slot_mem[hit_idx] <= slot_mem[hit_idx] | arr_oh;
        end else if (kind == ARR_JOIN) begin
            slot_vld[free_idx] <= 1'b1;
            slot_id[free_idx]  <= arrive_id;
            slot_mem[free_idx] <= arr_oh;
        end
    end

    // Error pulse for a rejected arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) arrive_error <= 1'b0;
        else        arrive_error <= (kind == ARR_REJECT);
    end

    // One state holder per warp.
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        barrier_warp_state #(.THR_W(THR_W)) u_state (
            .clk(clk), .rst_n(rst_n),
            .park_i(park_mask[w]), .release_i(rel_mask[w]),
            .load_i(load_mask[w]), .thr_i(arrive_threads),
            .stall_o(warp_stall[w]), .resume_o(warp_resume[w]),
            .saved_o(warp_threads[w*THR_W +: THR_W])
        );
    end

    // R6: no two open entries share an identifier.
    assert_unique_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R7: an error pulse always follows an arrival.
    assert_error_after_arrival_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arrive_error |-> $past(arrive_valid));

    // R7: a rejected arrival leaves stalls unchanged and releases nobody.
    assert_reject_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ARR_REJECT) |=> ($stable(warp_stall) && warp_resume == '0));

    // R5: a repeated arrival leaves stalls unchanged and releases nobody.
    assert_dup_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ARR_DUP) |=> ($stable(warp_stall) && warp_resume == '0));

    // R4: the completing warp is never stalled after its arrival.
    assert_completer_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ARR_DONE) |=> ((warp_stall & $past(arr_oh)) == '0));

endmodule

// File: tb/warp_barrier_unit_tb.sv
`timescale 1ns/1ps
module warp_barrier_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arrive_valid = 1'b0;
    logic [2:0] arrive_warp = '0;
    logic [3:0] arrive_id = '0;
    logic [3:0] arrive_need = '0;
    logic [3:0] arrive_threads = '0;
    logic [7:0] warp_stall, warp_resume;
    logic [31:0] warp_threads;
    logic       arrive_error;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    warp_barrier_unit u_dut (
        .clk(clk), .rst_n(rst_n), .arrive_valid(arrive_valid),
        .arrive_warp(arrive_warp), .arrive_id(arrive_id),
        .arrive_need(arrive_need), .arrive_threads(arrive_threads),
        .warp_stall(warp_stall), .warp_resume(warp_resume),
        .warp_threads(warp_threads), .arrive_error(arrive_error)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] thr(input int w);
        return warp_threads[w*4 +: 4];
    endfunction

    // Drive one arrival; returns just after the sampling edge (at negedge).
    task automatic arrive(input int w, input int id, input int need, input int t);
        @(negedge clk);
        arrive_valid   = 1'b1;
        arrive_warp    = 3'(w);
        arrive_id      = 4'(id);
        arrive_need    = 4'(need);
        arrive_threads = 4'(t);
        @(negedge clk);
        arrive_valid   = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 stall", warp_stall, 0);
        chk("R1 resume", warp_resume, 0);
        chk("R1 error", arrive_error, 0);
    endtask

    task automatic t_basic();
        arrive(0, 3, 3, 5);
        chk("R2 stall w0", warp_stall, 8'h01);
        chk("R2 saved w0", thr(0), 5);
        chk("R2 no resume", warp_resume, 0);
        arrive(2, 3, 3, 7);
        chk("R2 stall w0 w2", warp_stall, 8'h05);
        arrive(5, 3, 3, 2);
        chk("R3 stall cleared", warp_stall, 0);
        chk("R3 R4 resume", warp_resume, 8'h25);
        chk("R3 thr w0", thr(0), 5);
        chk("R3 thr w2", thr(2), 7);
        chk("R4 thr w5", thr(5), 2);
        idle();
        chk("R10 resume one cycle", warp_resume, 0);
    endtask

    task automatic t_dup();
        arrive(1, 9, 2, 3);
        chk("R5 first stall", warp_stall, 8'h02);
        arrive(1, 9, 2, 3);
        chk("R5 dup stall", warp_stall, 8'h02);
        chk("R5 dup resume", warp_resume, 0);
        arrive(4, 9, 2, 1);
        chk("R5 release resume", warp_resume, 8'h12);
        chk("R5 release stall", warp_stall, 0);
    endtask

    task automatic t_concurrent();
        arrive(0, 1, 2, 4);
        arrive(1, 2, 2, 6);
        chk("R6 two open", warp_stall, 8'h03);
        arrive(2, 1, 2, 8);
        chk("R6 id1 resume", warp_resume, 8'h05);
        chk("R6 id2 still stalled", warp_stall, 8'h02);
        arrive(3, 2, 2, 9);
        chk("R6 id2 resume", warp_resume, 8'h0A);
        chk("R6 all free", warp_stall, 0);
        chk("R6 thr w1", thr(1), 6);
    endtask

    task automatic t_full();
        arrive(0, 10, 2, 1);
        arrive(1, 11, 2, 1);
        arrive(2, 12, 2, 1);
        arrive(3, 13, 2, 1);
        chk("R7 table full", warp_stall, 8'h0F);
        arrive(4, 14, 2, 6);
        chk("R7 error pulse", arrive_error, 1);
        chk("R7 not stalled", warp_stall, 8'h0F);
        chk("R7 no resume", warp_resume, 0);
        idle();
        chk("R7 error one cycle", arrive_error, 0);
        arrive(5, 10, 2, 3);
        chk("R8 free one", warp_resume, 8'h21);
        chk("R8 stall", warp_stall, 8'h0E);
        arrive(4, 14, 2, 6);
        chk("R8 reuse no error", arrive_error, 0);
        chk("R8 reuse stall", warp_stall, 8'h1E);
        chk("R8 reuse saved", thr(4), 6);
        arrive(5, 11, 2, 1);
        arrive(6, 12, 2, 1);
        arrive(7, 13, 2, 1);
        arrive(0, 14, 2, 1);
        chk("R8 drained", warp_stall, 0);
        chk("R8 last resume", warp_resume, 8'h11);
    endtask

    task automatic t_single();
        arrive(0, 4, 2, 1);
        arrive(1, 5, 2, 1);
        arrive(2, 6, 2, 1);
        arrive(3, 7, 2, 1);
        arrive(6, 15, 1, 9);
        chk("R9 need1 resume", warp_resume, 8'h40);
        chk("R9 need1 no error", arrive_error, 0);
        chk("R9 need1 stall", warp_stall, 8'h0F);
        chk("R9 need1 thr", thr(6), 9);
        arrive(7, 15, 0, 11);
        chk("R9 need0 resume", warp_resume, 8'h80);
        chk("R9 need0 no error", arrive_error, 0);
        arrive(4, 4, 2, 1);
        chk("R9 table still held", warp_resume, 8'h11);
        arrive(5, 5, 2, 1);
        arrive(6, 6, 2, 1);
        arrive(7, 7, 2, 1);
        chk("R9 drained", warp_stall, 0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        t_reset();
        t_basic();
        t_dup();
        t_concurrent();
        t_full();
        t_single();
        idle();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

endmodule